// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running calendar (seconds, minutes, hours, day of month and day of week, all packed BCD) and compares it with five alarm registers. Each alarm register carries an active-low enable in its top bit, so software chooses which fields take part in the match: an alarm on seconds only fires once a minute, while an alarm on minutes and hours fires once a day. When every enabled field agrees with the calendar, a sticky alarm flag is raised, and an active-low interrupt request follows the flag while the interrupt enable is set.

The comparison is gated by a check strobe that the calendar logic issues once per second, after its counters have settled. The flag is raised only on the first strobe that sees a match, so a match that lasts several seconds (for example, a minute-only alarm) produces one event. Software clears the flag by writing 0 to it. Writing 1 has no effect. The 12/24-hour select tells the block how the hour fields are encoded. The calendar counters and the register access path sit outside this block.

Top module: `cal_alarm_match`

## Requirements
- R1: Bit 7 of each alarm register is an active-low enable (0 = field takes part, 1 = field ignored); a field whose enable is 1 cannot block a match, whatever its value.
- R2: When all five alarm registers have bit 7 set, the alarm flag never rises, whatever the calendar values and strobes.
- R3: Only value bits are compared: bits 6:0 for seconds and minutes, bits 5:0 for hours and day of month, bits 2:0 for day of week; any other calendar bit (for example bit 7 of seconds) is ignored.
- R4: In 24-hour mode (hour select 0) the hour fields hold BCD 00 to 23 in bits 5:0. In 12-hour mode (hour select 1) bit 5 is the PM marker (1 = PM) and bits 4:0 hold BCD 01 to 12, so the same clock hour in AM and PM does not match.
- R5: The flag rises only at a clock edge where the check strobe is high and all enabled fields match; it reads 1 from the cycle after that edge, and a match without a strobe leaves it unchanged.
- R6: A match raises the flag only on its first strobe; later strobes that still match do not raise it again until a strobe has seen a mismatch.
- R7: A flag write with data 0 clears the flag on the next edge; a flag write with data 1 leaves the flag unchanged.
- R8: When a flag set and a clearing write happen at the same edge, the set wins and the flag reads 1.
- R9: The interrupt output is low exactly while the flag is 1 and the interrupt enable is 1; otherwise it is high.
- R10: Reset clears the flag (interrupt output high) and the match history, so the first matching strobe after reset raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_sec_i | input | 8 | Calendar seconds, BCD |
| cal_min_i | input | 8 | Calendar minutes, BCD |
| cal_hour_i | input | 8 | Calendar hours, BCD, encoding per hour select |
| cal_date_i | input | 8 | Calendar day of month, BCD |
| cal_wday_i | input | 8 | Calendar day of week, 0 to 6 |
| chk_stb_i | input | 1 | Once-per-second compare strobe |
| alm_sec_i | input | 8 | Seconds alarm: bit 7 enable (low active), value below |
| alm_min_i | input | 8 | Minutes alarm |
| alm_hour_i | input | 8 | Hours alarm |
| alm_date_i | input | 8 | Day-of-month alarm |
| alm_wday_i | input | 8 | Day-of-week alarm |
| irq_en_i | input | 1 | Alarm interrupt enable |
| hr12_i | input | 1 | Hour encoding: 1 = 12-hour with PM bit, 0 = 24-hour |
| flag_wr_i | input | 1 | Write strobe for the alarm flag |
| flag_wdata_i | input | 1 | Written flag value (0 clears, 1 keeps) |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that the check strobe and the flag write are single-cycle pulses that are synchronous to the clock, and that the alarm registers and calendar values are stable around a strobe. They also assume that the hour select does not change while a match is pending. The bench changes calendar values, alarm values and the hour select only on falling edges while the strobe is low. It raises the strobe for exactly one cycle and issues flag writes as one-cycle pulses. Each match scenario first runs a mismatching strobe, so the match history starts from a known value before a set is expected.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

   // number of compared calendar fields
   localparam int unsigned NUM_FIELDS = 5;

   typedef enum logic [2:0] {
      FLD_SEC  = 3'd0,
      FLD_MIN  = 3'd1,
      FLD_HOUR = 3'd2,
      FLD_DATE = 3'd3,
      FLD_WDAY = 3'd4
   } field_e;

   // value bits of each field (enable bit and unused bits excluded)
   localparam logic [7:0] MASK_SEC    = 8'h7F;
   localparam logic [7:0] MASK_MIN    = 8'h7F;
   localparam logic [7:0] MASK_HR24   = 8'h3F;   // tens 5:4, units 3:0
   localparam logic [7:0] PM_BIT      = 8'h20;
   localparam logic [7:0] MASK_HR12D  = 8'h1F;   // tens 4, units 3:0
   localparam logic [7:0] MASK_DATE   = 8'h3F;
   localparam logic [7:0] MASK_WDAY   = 8'h07;

   function automatic logic [7:0] mask_24h(input int unsigned idx);
      case (idx)
         0:       return MASK_SEC;
         1:       return MASK_MIN;
         2:       return MASK_HR24;
         3:       return MASK_DATE;
         default: return MASK_WDAY;
      endcase
   endfunction

   function automatic logic [7:0] mask_12h(input int unsigned idx);
      if (idx == 2) return PM_BIT | MASK_HR12D;
      return mask_24h(idx);
   endfunction

endpackage

// File: rtl/cal_alarm_field.sv
// One field: decides whether the field takes part and whether it agrees.
module cal_alarm_field #(
   parameter int unsigned   DATA_W   = 8,
   parameter int unsigned   ENA_BIT  = DATA_W - 1,
   parameter logic [DATA_W-1:0] MASK_A = '1,   // mask with hour select 0
   parameter logic [DATA_W-1:0] MASK_B = '1    // mask with hour select 1
) (
   input  logic [DATA_W-1:0] cal_val,
   input  logic [DATA_W-1:0] alm_reg,
   input  logic              mode_b,
   output logic              active,
   output logic              agree
);

   localparam logic [DATA_W-1:0] ENA_MASK = DATA_W'(1) << ENA_BIT;

   if (ENA_BIT >= DATA_W) begin : g_bad_ena
      $error("cal_alarm_field: enable bit outside register");
   end
   if (((MASK_A | MASK_B) & ENA_MASK) != '0) begin : g_bad_mask
      $error("cal_alarm_field: value mask overlaps enable bit");
   end

   logic [DATA_W-1:0] sel_mask;
   logic [DATA_W-1:0] diff;

   // a variant without a mode dependency folds the mux away
   if (MASK_A == MASK_B) begin : g_fixed
      logic unused_mode;
      assign unused_mode = mode_b;
      assign sel_mask    = MASK_A;
   end else begin : g_moded
      assign sel_mask = mode_b ? MASK_B : MASK_A;
   end

   assign diff   = (cal_val ^ alm_reg) & sel_mask;
   assign active = ~alm_reg[ENA_BIT];
   assign agree  = (diff == '0);

endmodule

// File: rtl/cal_alarm_reduce.sv
// Combines per-field results: a match needs at least one active field
// and agreement on every active one.
module cal_alarm_reduce #(
   parameter int unsigned N = 5
) (
   input  logic [N-1:0] active,
   input  logic [N-1:0] agree,
   output logic         match
);

   if (N < 1) begin : g_bad_n
      $error("cal_alarm_reduce: needs at least one field");
   end

   logic [N-1:0] pass;

   for (genvar i = 0; i < N; i++) begin : g_pass
      assign pass[i] = agree[i] | ~active[i];
   end

   assign match = (|active) & (&pass);

endmodule

// File: rtl/cal_alarm_flag.sv
// Sticky flag with first-strobe set, clear-by-zero write and interrupt gate.
module cal_alarm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic chk_stb,
   input  logic match,
   input  logic wr,
   input  logic wdata,
   input  logic irq_en,
   output logic flag,
   output logic irq_n
);

   logic prev_match;
   logic set_evt;
   logic clr_evt;

   assign set_evt = chk_stb & match & ~prev_match;
   assign clr_evt = wr & ~wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_match <= 1'b0;
      end else if (chk_stb) begin
         prev_match <= match;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (set_evt) begin
         flag <= 1'b1;
      end else if (clr_evt) begin
         flag <= 1'b0;
      end
   end

   assign irq_n = ~(flag & irq_en);

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ENA_BIT = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] cal_sec_i,
   input  logic [DATA_W-1:0] cal_min_i,
   input  logic [DATA_W-1:0] cal_hour_i,
   input  logic [DATA_W-1:0] cal_date_i,
   input  logic [DATA_W-1:0] cal_wday_i,
   input  logic              chk_stb_i,
   input  logic [DATA_W-1:0] alm_sec_i,
   input  logic [DATA_W-1:0] alm_min_i,
   input  logic [DATA_W-1:0] alm_hour_i,
   input  logic [DATA_W-1:0] alm_date_i,
   input  logic [DATA_W-1:0] alm_wday_i,
   input  logic              irq_en_i,
   input  logic              hr12_i,
   input  logic              flag_wr_i,
   input  logic              flag_wdata_i,
   output logic              alarm_flag_o,
   output logic              irq_n_o
);
   import cal_alarm_pkg::*;

   localparam int unsigned NF = NUM_FIELDS;

   if (DATA_W < 8) begin : g_bad_width
      $error("cal_alarm_match: fields need at least 8 bits");
   end

   logic [DATA_W-1:0] cal_arr [NF];
   logic [DATA_W-1:0] alm_arr [NF];
   logic [NF-1:0]     fld_active;
   logic [NF-1:0]     fld_agree;
   logic              all_match;

   assign cal_arr[FLD_SEC]  = cal_sec_i;
   assign cal_arr[FLD_MIN]  = cal_min_i;
   assign cal_arr[FLD_HOUR] = cal_hour_i;
   assign cal_arr[FLD_DATE] = cal_date_i;
   assign cal_arr[FLD_WDAY] = cal_wday_i;

   assign alm_arr[FLD_SEC]  = alm_sec_i;
   assign alm_arr[FLD_MIN]  = alm_min_i;
   assign alm_arr[FLD_HOUR] = alm_hour_i;
   assign alm_arr[FLD_DATE] = alm_date_i;
   assign alm_arr[FLD_WDAY] = alm_wday_i;

   for (genvar f = 0; f < NF; f++) begin : g_field
      cal_alarm_field #(
         .DATA_W  (DATA_W),
         .ENA_BIT (ENA_BIT),
         .MASK_A  (DATA_W'(mask_24h(f))),
         .MASK_B  (DATA_W'(mask_12h(f)))
      ) u_field (
         .cal_val (cal_arr[f]),
         .alm_reg (alm_arr[f]),
         .mode_b  (hr12_i),
         .active  (fld_active[f]),
         .agree   (fld_agree[f])
      );
   end

   cal_alarm_reduce #(
      .N (NF)
   ) u_reduce (
      .active (fld_active),
      .agree  (fld_agree),
      .match  (all_match)
   );

   cal_alarm_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .chk_stb (chk_stb_i),
      .match   (all_match),
      .wr      (flag_wr_i),
      .wdata   (flag_wdata_i),
      .irq_en  (irq_en_i),
      .flag    (alarm_flag_o),
      .irq_n   (irq_n_o)
   );

endmodule

// File: rtl/cal_alarm_match_chk.sv
module cal_alarm_match_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       chk_stb_i,
   input logic       flag_wr_i,
   input logic       flag_wdata_i,
   input logic       irq_en_i,
   input logic [4:0] dis_bits,
   input logic       alarm_flag_o,
   input logic       irq_n_o
);

   // R5
   flag_rise_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag_o) |-> $past(chk_stb_i));

   // R5
   flag_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_stb_i && !flag_wr_i) |=> $stable(alarm_flag_o));

   // R7
   flag_clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr_i && !flag_wdata_i && !chk_stb_i) |=> !alarm_flag_o);

   // R7
   flag_write_one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr_i && flag_wdata_i) |=> alarm_flag_o || !$past(alarm_flag_o));

   // R2
   all_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((&dis_bits) && !flag_wr_i) |=> $stable(alarm_flag_o));

   // R9
   irq_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_flag_o || !irq_en_i) |-> irq_n_o);

   // R9
   irq_active_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag_o && irq_en_i) |-> !irq_n_o);

endmodule

bind cal_alarm_match cal_alarm_match_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .chk_stb_i    (chk_stb_i),
   .flag_wr_i    (flag_wr_i),
   .flag_wdata_i (flag_wdata_i),
   .irq_en_i     (irq_en_i),
   .dis_bits     ({alm_sec_i[7], alm_min_i[7], alm_hour_i[7], alm_date_i[7], alm_wday_i[7]}),
   .alarm_flag_o (alarm_flag_o),
   .irq_n_o      (irq_n_o)
);

// File: tb/cal_alarm_match_bench.sv
module cal_alarm_match_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cal_sec = 8'h00, cal_min = 8'h00, cal_hour = 8'h00;
   logic [7:0] cal_date = 8'h01, cal_wday = 8'h00;
   logic       chk_stb = 1'b0;
   logic [7:0] alm_sec = 8'h80, alm_min = 8'h80, alm_hour = 8'h80;
   logic [7:0] alm_date = 8'h80, alm_wday = 8'h80;
   logic       irq_en = 1'b0, hr12 = 1'b0;
   logic       flag_wr = 1'b0, flag_wdata = 1'b0;
   logic       alarm_flag, irq_n;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   cal_alarm_match u_cal_alarm_match (
      .clk          (clk),
      .rst_n        (rst_n),
      .cal_sec_i    (cal_sec),
      .cal_min_i    (cal_min),
      .cal_hour_i   (cal_hour),
      .cal_date_i   (cal_date),
      .cal_wday_i   (cal_wday),
      .chk_stb_i    (chk_stb),
      .alm_sec_i    (alm_sec),
      .alm_min_i    (alm_min),
      .alm_hour_i   (alm_hour),
      .alm_date_i   (alm_date),
      .alm_wday_i   (alm_wday),
      .irq_en_i     (irq_en),
      .hr12_i       (hr12),
      .flag_wr_i    (flag_wr),
      .flag_wdata_i (flag_wdata),
      .alarm_flag_o (alarm_flag),
      .irq_n_o      (irq_n)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic expect_flag(input string tag, input logic exp);
      check(alarm_flag === exp, tag, int'(alarm_flag), int'(exp));
   endtask

   // one-cycle strobe; returns on the falling edge after the compare edge
   task automatic strobe();
      @(negedge clk) chk_stb = 1'b1;
      @(negedge clk) chk_stb = 1'b0;
   endtask

   task automatic write_flag(input logic v);
      @(negedge clk) begin flag_wr = 1'b1; flag_wdata = v; end
      @(negedge clk) flag_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      expect_flag("R10 flag after reset", 1'b0);
      check(irq_n === 1'b1, "R10 irq after reset", int'(irq_n), 1);
   endtask

   task automatic t_all_disabled();
      cal_sec = 8'h00; cal_min = 8'h00;
      strobe();
      expect_flag("R2 all disabled, first strobe", 1'b0);
      cal_sec = 8'h45;
      strobe();
      expect_flag("R2 all disabled, second strobe", 1'b0);
   endtask

   task automatic t_single();
      alm_sec = 8'h30; cal_sec = 8'h29;
      strobe();
      cal_sec = 8'h30;
      idle(3);
      expect_flag("R5 match without strobe", 1'b0);
      strobe();
      expect_flag("R5 match with strobe", 1'b1);
      check(irq_n === 1'b1, "R9 irq masked", int'(irq_n), 1);
      @(negedge clk) irq_en = 1'b1;
      #1 check(irq_n === 1'b0, "R9 irq enabled", int'(irq_n), 0);
      @(negedge clk) irq_en = 1'b0;
   endtask

   task automatic t_clear();
      write_flag(1'b1);
      expect_flag("R7 write one keeps flag", 1'b1);
      write_flag(1'b0);
      expect_flag("R7 write zero clears flag", 1'b0);
   endtask

   task automatic t_once();
      strobe();
      expect_flag("R6 repeated match no re-set", 1'b0);
      cal_sec = 8'h31;
      strobe();
      expect_flag("R6 mismatch strobe", 1'b0);
      cal_sec = 8'h30;
      strobe();
      expect_flag("R6 new match sets again", 1'b1);
      write_flag(1'b0);
   endtask

   task automatic t_multi();
      alm_sec = 8'h30; alm_min = 8'h15; alm_hour = 8'h87; alm_date = 8'h89;
      cal_sec = 8'h30; cal_min = 8'h16; cal_hour = 8'h11; cal_date = 8'h02;
      strobe();
      expect_flag("R1 enabled minutes differ", 1'b0);
      cal_min = 8'h15;
      strobe();
      expect_flag("R1 disabled fields ignored", 1'b1);
      write_flag(1'b0);
   endtask

   task automatic t_value_bits();
      alm_wday = 8'h05; cal_wday = 8'h05;
      cal_sec = 8'h31;
      strobe();
      cal_sec = 8'hB0; cal_wday = 8'hF5;
      strobe();
      expect_flag("R3 upper calendar bits ignored", 1'b1);
      write_flag(1'b0);
      alm_wday = 8'h80; cal_wday = 8'h00;
   endtask

   task automatic t_hours();
      alm_sec = 8'h80; alm_min = 8'h80; alm_hour = 8'h21;
      hr12 = 1'b0; cal_hour = 8'h20;
      strobe();
      cal_hour = 8'h21;
      strobe();
      expect_flag("R4 24-hour match 21h", 1'b1);
      write_flag(1'b0);
      hr12 = 1'b1; cal_hour = 8'h01;
      strobe();
      expect_flag("R4 12-hour AM vs PM alarm", 1'b0);
      cal_hour = 8'h21;
      strobe();
      expect_flag("R4 12-hour PM match", 1'b1);
      write_flag(1'b0);
      hr12 = 1'b0;
   endtask

   task automatic t_set_wins();
      cal_hour = 8'h05;
      strobe();
      cal_hour = 8'h21;
      @(negedge clk) begin chk_stb = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b0; end
      @(negedge clk) begin chk_stb = 1'b0; flag_wr = 1'b0; end
      expect_flag("R8 set beats clear", 1'b1);
   endtask

   task automatic t_mid_reset();
      @(negedge clk) rst_n = 1'b0;
      #1 expect_flag("R10 flag cleared by reset", 1'b0);
      check(irq_n === 1'b1, "R10 irq high in reset", int'(irq_n), 1);
      @(negedge clk) rst_n = 1'b1;
      strobe();
      expect_flag("R10 history cleared, first match sets", 1'b1);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_all_disabled();
      t_single();
      t_clear();
      t_once();
      t_multi();
      t_value_bits();
      t_hours();
      t_set_wins();
      t_mid_reset();
      idle(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule